// File: doc/BRIEF.md
# Autonegotiation Result Validator with Retry

This block sits beside a copper link's management logic and decides whether a finished autonegotiation can be trusted. Each time negotiation reports completion, it looks at three words together: the partner ability word, the expansion word and a low-power status word that carries a hidden completion flag. If the result passes, the block accepts it. It raises a one-cycle valid pulse and holds the partner ability word on its output. If the result looks corrupted, it sends a one-cycle restart pulse back to the negotiation engine and waits for the next completion.

A parameterised retry budget limits how many restarts happen in a row. When an invalid result arrives after the budget is used up, the block raises a sticky failure flag and does not restart again until reset. When negotiation is disabled, completions are accepted without any check.

Top module: `aneg_result_checker`

## Requirements
- R1: While `aneg_en_i` is low, a `done_i` pulse is accepted without checking, whatever the status words hold. `valid_o` pulses and `ability_o` takes `lpa_i`. No restart is issued.
- R2: With `aneg_en_i` high, a completion is invalid when bit 12 of `lpi_word_i` is clear.
- R3: With `aneg_en_i` high, a completion is invalid when bit 0 of `exp_word_i` is set and bit 14 of `lpa_i` is clear. When bit 0 of `exp_word_i` is clear, bit 14 is not checked.
- R4: With `aneg_en_i` high, a partner ability word of exactly 0x0001 is invalid even when bit 0 of `exp_word_i` is clear.
- R5: A valid completion sampled at clock edge N gives a one-cycle `valid_o` pulse after edge N. `ability_o` then equals the sampled `lpa_i` and holds until the next accepted completion.
- R6: An invalid completion sampled at edge N gives a one-cycle `restart_o` pulse after edge N, while no retry budget is exhausted. `ability_o` does not change. Neither `restart_o` nor `valid_o` is ever raised without a `done_i` pulse on the previous edge.
- R7: After MAX_RETRY consecutive restarts (default 6), the next invalid completion sets `fail_o` and issues no restart. `fail_o` stays set until reset, and while it is set no restart is issued. Valid completions are still accepted.
- R8: An accepted completion clears the retry count, so MAX_RETRY further restarts are again available.
- R9: Any clock edge with `aneg_en_i` low clears the retry count.
- R10: After reset, `restart_o`, `valid_o`, `fail_o` and `ability_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| aneg_en_i | input | 1 | Autonegotiation enabled |
| done_i | input | 1 | One-cycle pulse: negotiation reports completion |
| lpa_i | input | 16 | Partner ability word (bit 14 = acknowledge) |
| exp_word_i | input | 16 | Expansion word (bit 0 = partner can negotiate) |
| lpi_word_i | input | 16 | Low-power status word (bit 12 = hidden completion flag) |
| restart_o | output | 1 | One-cycle restart request |
| valid_o | output | 1 | One-cycle pulse: result accepted |
| ability_o | output | 16 | Last accepted partner ability word |
| fail_o | output | 1 | Sticky: retry budget exhausted |

## Verification
The check is driven with these completions:
- A clean result.
- A result with the hidden flag clear.
- A result whose acknowledge bit is clear, both with and without the partner-capable flag. This separates the acknowledge rule from a plain bit test.
- The exact word 0x0001 with the partner-capable flag clear. This isolates the early-failure rule.
- Completions while negotiation is disabled, carrying words that would otherwise fail. These show that the check is bypassed.

Runs of back-to-back invalid completions probe the retry budget. The bench confirms that a restart count exactly equal to the budget is allowed and that the next invalid completion sets the failure flag. Between the runs it inserts either an accepted result or a disabled cycle, which shows that each of them resets the count.

// File: rtl/aneg_chk_pkg.sv
package aneg_chk_pkg;
  localparam int WORD_W       = 16;
  localparam int ACK_BIT      = 14;  // acknowledge in partner ability word
  localparam int CAPABLE_BIT  = 0;   // partner can negotiate, expansion word
  localparam int HIDDEN_BIT   = 12;  // completion flag, low-power status word
  localparam logic [WORD_W-1:0] EARLY_FAIL_WORD = 16'h0001;

  typedef enum logic [1:0] {
    ACT_NONE    = 2'd0,
    ACT_ACCEPT  = 2'd1,
    ACT_RESTART = 2'd2,
    ACT_GIVEUP  = 2'd3
  } action_e;
endpackage

// File: rtl/aneg_word_check.sv
module aneg_word_check
  import aneg_chk_pkg::*;
#(
  parameter int W = WORD_W
) (
  input  logic [W-1:0] lpa_i,
  input  logic [W-1:0] exp_word_i,
  input  logic [W-1:0] lpi_word_i,
  output logic         bad_o
);
  logic hidden_missing;
  logic ack_missing;
  logic early_word;

  always_comb begin
    hidden_missing = ~lpi_word_i[HIDDEN_BIT];
    ack_missing    = exp_word_i[CAPABLE_BIT] & ~lpa_i[ACK_BIT];
    early_word     = (lpa_i == W'(EARLY_FAIL_WORD));
    bad_o          = hidden_missing | ack_missing | early_word;
  end
endmodule

// File: rtl/aneg_retry_ctr.sv
module aneg_retry_ctr #(
  parameter int MAX_RETRY = 6,
  localparam int CNT_W = $clog2(MAX_RETRY + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic inc_i,
  input  logic clr_i,
  output logic at_limit_o
);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(MAX_RETRY);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = clr_i | inc_i;
    cnt_d  = cnt_q;
    if (clr_i)
      cnt_d = '0;
    else if (inc_i && cnt_q != LIMIT)
      cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (cnt_en)
      cnt_q <= cnt_d;
  end

  assign at_limit_o = (cnt_q == LIMIT);
endmodule

// File: rtl/aneg_result_out.sv
module aneg_result_out
  import aneg_chk_pkg::*;
#(
  parameter int W = WORD_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  action_e      act_i,
  input  logic [W-1:0] lpa_i,
  output logic         restart_o,
  output logic         valid_o,
  output logic [W-1:0] ability_o,
  output logic         fail_o
);
  logic         restart_d, valid_d, fail_d, ability_en;
  logic [W-1:0] ability_q;
  logic         restart_q, valid_q, fail_q;

  always_comb begin
    restart_d  = (act_i == ACT_RESTART);
    valid_d    = (act_i == ACT_ACCEPT);
    fail_d     = fail_q | (act_i == ACT_GIVEUP);
    ability_en = (act_i == ACT_ACCEPT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      restart_q <= 1'b0;
      valid_q   <= 1'b0;
      fail_q    <= 1'b0;
    end else begin
      restart_q <= restart_d;
      valid_q   <= valid_d;
      fail_q    <= fail_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      ability_q <= '0;
    else if (ability_en)
      ability_q <= lpa_i;
  end

  assign restart_o = restart_q;
  assign valid_o   = valid_q;
  assign fail_o    = fail_q;
  assign ability_o = ability_q;
endmodule

// File: rtl/aneg_result_checker.sv
module aneg_result_checker
  import aneg_chk_pkg::*;
#(
  parameter int MAX_RETRY = 6,
  parameter int W         = WORD_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         aneg_en_i,
  input  logic         done_i,
  input  logic [W-1:0] lpa_i,
  input  logic [W-1:0] exp_word_i,
  input  logic [W-1:0] lpi_word_i,
  output logic         restart_o,
  output logic         valid_o,
  output logic [W-1:0] ability_o,
  output logic         fail_o
);
  logic    bad;
  logic    at_limit;
  action_e act;

  aneg_word_check #(.W(W)) u_check (
    .lpa_i      (lpa_i),
    .exp_word_i (exp_word_i),
    .lpi_word_i (lpi_word_i),
    .bad_o      (bad)
  );

  always_comb begin
    act = ACT_NONE;
    if (done_i) begin
      if (!aneg_en_i || !bad)
        act = ACT_ACCEPT;
      else if (!fail_o)
        act = at_limit ? ACT_GIVEUP : ACT_RESTART;
    end
  end

  aneg_retry_ctr #(.MAX_RETRY(MAX_RETRY)) u_ctr (
    .clk        (clk),
    .rst_n      (rst_n),
    .inc_i      (act == ACT_RESTART),
    .clr_i      ((act == ACT_ACCEPT) || !aneg_en_i),
    .at_limit_o (at_limit)
  );

  aneg_result_out #(.W(W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .act_i     (act),
    .lpa_i     (lpa_i),
    .restart_o (restart_o),
    .valid_o   (valid_o),
    .ability_o (ability_o),
    .fail_o    (fail_o)
  );
endmodule

// File: rtl/aneg_result_checker_sva.sv
module aneg_result_checker_sva #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         aneg_en_i,
  input logic         done_i,
  input logic [W-1:0] lpa_i,
  input logic [W-1:0] lpi_word_i,
  input logic         restart_o,
  input logic         valid_o,
  input logic [W-1:0] ability_o,
  input logic         fail_o
);
  assert_restart_needs_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    restart_o |-> $past(done_i && aneg_en_i));

  assert_valid_needs_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> $past(done_i));

  assert_single_verdict_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(valid_o && restart_o));

  assert_bypass_capture_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && $past(!aneg_en_i)) |-> ability_o == $past(lpa_i));

  assert_hidden_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && $past(aneg_en_i)) |-> $past(lpi_word_i[12]));

  assert_ability_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> $stable(ability_o));

  assert_fail_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fail_o |=> fail_o);

  assert_no_restart_after_fail_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fail_o |=> !restart_o);
endmodule

bind aneg_result_checker aneg_result_checker_sva #(.W(W)) u_sva (
  .clk        (clk),
  .rst_n      (rst_n),
  .aneg_en_i  (aneg_en_i),
  .done_i     (done_i),
  .lpa_i      (lpa_i),
  .lpi_word_i (lpi_word_i),
  .restart_o  (restart_o),
  .valid_o    (valid_o),
  .ability_o  (ability_o),
  .fail_o     (fail_o)
);

// File: tb/aneg_result_checker_tb.sv
module aneg_result_checker_tb;
  localparam int MAX = 6;

  typedef struct {
    logic        rs;
    logic        vl;
    logic        fl;
    logic [15:0] ab;
    string       req;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        en, done;
  logic [15:0] lpa, expw, lpi;
  logic        restart, valid, fail;
  logic [15:0] ability;

  exp_t q[$];
  int   n_chk = 0, n_fail = 0;
  int   m_cnt = 0;
  logic m_fail = 1'b0;
  logic [15:0] m_ab = '0;

  always #5 clk = ~clk;

  aneg_result_checker #(.MAX_RETRY(MAX)) u_dut (
    .clk(clk), .rst_n(rst_n), .aneg_en_i(en), .done_i(done),
    .lpa_i(lpa), .exp_word_i(expw), .lpi_word_i(lpi),
    .restart_o(restart), .valid_o(valid), .ability_o(ability), .fail_o(fail)
  );

  task automatic chk(input string req, input logic [18:0] act, input logic [18:0] expd);
    n_chk++;
    if (act !== expd) begin
      n_fail++;
      $display("FAIL %s: rs/vl/fl/ab actual=%h expected=%h", req, act, expd);
    end
  endtask

  // driver: one completion per call, expected verdict pushed to scoreboard
  task automatic comp(input logic e, input logic [15:0] a, input logic [15:0] x,
                      input logic [15:0] l, input string req);
    exp_t it;
    logic bad;
    @(negedge clk);
    en = e; done = 1'b1; lpa = a; expw = x; lpi = l;
    bad = !l[12] || (x[0] && !a[14]) || (a == 16'h0001);
    it = '{rs: 1'b0, vl: 1'b0, fl: m_fail, ab: m_ab, req: req};
    if (!e || !bad) begin
      it.vl = 1'b1; m_ab = a; it.ab = a; m_cnt = 0;
    end else if (!m_fail) begin
      if (m_cnt < MAX) begin it.rs = 1'b1; m_cnt++; end
      else begin m_fail = 1'b1; it.fl = 1'b1; end
    end
    q.push_back(it);
  endtask

  task automatic idle(input int n, input logic e);
    repeat (n) begin
      @(negedge clk);
      done = 1'b0; en = e;
      if (!e) m_cnt = 0;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; done = 1'b0;
    m_cnt = 0; m_fail = 1'b0; m_ab = '0;
    repeat (2) @(negedge clk);
    chk("R10", {restart, valid, fail, ability}, 19'h0);
    rst_n = 1'b1;
  endtask

  // monitor: pops the scoreboard after each edge; idle cycles must be quiet
  always @(posedge clk) begin
    #2;
    if (rst_n) begin
      if (q.size() > 0) begin
        exp_t it;
        it = q.pop_front();
        chk(it.req, {restart, valid, fail, ability}, {it.rs, it.vl, it.fl, it.ab});
      end else begin
        chk("R6 idle", {restart, valid, fail}, {1'b0, 1'b0, m_fail});
      end
    end
  end

  initial begin
    #1000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; en = 1'b1; done = 1'b0; lpa = '0; expw = '0; lpi = '0;
    do_reset();
    comp(1, 16'h45E1, 16'h0001, 16'h1000, "R5 clean");
    comp(1, 16'h05E1, 16'h0000, 16'h1000, "R3 ack not needed");
    idle(2, 1);
    comp(1, 16'h45E1, 16'h0001, 16'h0000, "R2 hidden clear");
    comp(1, 16'h05E1, 16'h0001, 16'hF000, "R3 ack missing");
    comp(1, 16'h0001, 16'h0000, 16'h1000, "R4 early word");
    idle(1, 1);
    comp(1, 16'h41E1, 16'h0001, 16'h1000, "R8 accept");
    comp(0, 16'h0001, 16'h0001, 16'h0000, "R1 bypass");
    idle(1, 1);
    for (int i = 0; i < MAX; i++) comp(1, 16'h45E1, 16'h0, 16'h0, "R8 budget refilled");
    comp(1, 16'h45E1, 16'h0001, 16'h1000, "R8 accept after restarts");
    for (int i = 0; i < 3; i++) comp(1, 16'h0001, 16'h0, 16'h1000, "R6 restart");
    idle(2, 0);
    idle(1, 1);
    for (int i = 0; i < MAX; i++) comp(1, 16'h0521, 16'h1, 16'h1000, "R9 count cleared");
    comp(1, 16'h0521, 16'h1, 16'h1000, "R7 limit reached");
    idle(2, 1);
    comp(1, 16'h0000, 16'h0, 16'h0000, "R7 no restart after fail");
    comp(1, 16'h4DE1, 16'h1, 16'h1000, "R7 accept while failed");
    comp(1, 16'h0001, 16'h0, 16'h1000, "R7 still no restart");
    idle(3, 1);
    do_reset();
    comp(1, 16'h0000, 16'h0, 16'h0000, "R10 restart after reset");
    idle(3, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule